// File: doc/BRIEF.md
# Instruction Phase Sequencer

This block is the control state machine that walks a single CPU instruction through its phases. It requests the instruction word from the bus with the program counter as the address. It then starts microcode routines that bring in the operands, gives the instruction lookup one cycle, and hands control to the instruction's own microcode. When that microcode reports it is finished, the sequencer goes back to fetching.

The first phase after a fetch depends on how many operands the opcode needs. Two-operand words run both operand phases. One-operand words go straight to the destination phase. Zero-operand and special words (branch, mask, software interrupt, jump, call) go straight to the lookup.

While an operand phase is active, the sequencer tells the lookup logic to use the addressing-mode routine group. The microcode stores the result and advances the program counter.

Top module: `instr_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch phase with `mc_start`, `alu_left_en`, `alu_right_en`, `lookup_en` and `op_grp_zero` all low. A reset in any phase has this effect at the next edge.
- R2: In the fetch phase `fetch_req` is high and the sequencer waits there until `bus_done`. `ir_load` equals `bus_done` in the fetch phase and is low in every other phase.
- R3: A fetched word whose bits 15:12 are not 1111 is a two-operand word. The next phase is the source operand phase.
- R4: A fetched word with bits 15:12 = 1111 and bits 11:9 = 110 is a one-operand word. The next phase is the destination operand phase.
- R5: Every other word with bits 15:12 = 1111 goes from fetch directly to the lookup phase. This covers branch (bit 11 = 0), special (bits 11:10 = 10) and plain zero-operand words (bits 11:6 all ones, bits 5:4 = 00).
- R6: The phases run in the order fetch, source, destination, lookup, execute, then back to fetch. `phase` reports them with the codes 0, 1, 2, 3 and 4.
- R7: `mc_start` is a single-cycle pulse. It is high in the first cycle of the source, destination and execute phases and low in every other cycle.
- R8: The source, destination and execute phases hold until `mc_done` is seen, and the phase advances at the next edge. `mc_done` is ignored in the cycle of the start pulse and in all other phases. `bus_done` is ignored outside the fetch phase.
- R9: `alu_left_en` is high only in the source phase and `alu_right_en` only in the destination phase. `op_grp_zero`, which forces the upper lookup bits to 000, is high only in those two phases.
- R10: The lookup phase lasts exactly one cycle with `lookup_en` high, and the execute phase follows it.
- R11: An accepted `mc_done` in the execute phase returns the sequencer to the fetch phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_word | input | 16 | Instruction word from the bus, valid with bus_done |
| bus_done | input | 1 | Bus has delivered the instruction word |
| mc_done | input | 1 | Microcode routine finished |
| fetch_req | output | 1 | Route PC to the address latch and request a bus read |
| ir_load | output | 1 | Load the instruction register |
| alu_left_en | output | 1 | Source operand goes to the left ALU latch |
| alu_right_en | output | 1 | Destination operand goes to the right ALU latch |
| op_grp_zero | output | 1 | Force upper lookup-address bits to 000 |
| lookup_en | output | 1 | Instruction start-address lookup strobe |
| mc_start | output | 1 | One-cycle microcode start request |
| phase | output | 3 | Current phase code |

## Verification
A wrong phase register shows up immediately, because every strobe and the `phase` code depend on it in the same cycle. A wrong choice of entry phase shows one cycle after `bus_done`, as a missing or extra start pulse with the wrong latch select. A start flag that is set wrongly shows as a start pulse that lasts too long. It can also show as `mc_done` being accepted in the start cycle, and the phase then moves one cycle too early.

// File: rtl/instr_seq.sv
module instr_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] instr_word,
  input  logic        bus_done,
  input  logic        mc_done,
  output logic        fetch_req,
  output logic        ir_load,
  output logic        alu_left_en,
  output logic        alu_right_en,
  output logic        op_grp_zero,
  output logic        lookup_en,
  output logic        mc_start,
  output logic [2:0]  phase
);
  localparam logic [2:0] PH_FETCH = 3'd0;
  localparam logic [2:0] PH_SRC   = 3'd1;
  localparam logic [2:0] PH_DST   = 3'd2;
  localparam logic [2:0] PH_LOOK  = 3'd3;
  localparam logic [2:0] PH_EXEC  = 3'd4;

  logic       first;
  logic       prefix_f;
  logic       one_op;
  logic [2:0] entry;
  logic       done_ok;

  assign prefix_f = &instr_word[15:12];
  assign one_op   = prefix_f && (instr_word[11:9] == 3'b110);
  assign entry    = !prefix_f ? PH_SRC : (one_op ? PH_DST : PH_LOOK);
  assign done_ok  = mc_done && !first;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
      first <= 1'b0;
    end else begin
      first <= 1'b0;
      case (phase)
        PH_FETCH: if (bus_done) begin
          phase <= entry;
          first <= (entry != PH_LOOK);
        end
        PH_SRC: if (done_ok) begin
          phase <= PH_DST;
          first <= 1'b1;
        end
        PH_DST: if (done_ok) phase <= PH_LOOK;
        PH_LOOK: begin
          phase <= PH_EXEC;
          first <= 1'b1;
        end
        PH_EXEC: if (done_ok) phase <= PH_FETCH;
        default: phase <= PH_FETCH;
      endcase
    end
  end

  assign fetch_req    = (phase == PH_FETCH);
  assign ir_load      = fetch_req && bus_done;
  assign alu_left_en  = (phase == PH_SRC);
  assign alu_right_en = (phase == PH_DST);
  assign op_grp_zero  = alu_left_en || alu_right_en;
  assign lookup_en    = (phase == PH_LOOK);
  assign mc_start     = first;
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_done,
  input logic       mc_done,
  input logic       fetch_req,
  input logic       ir_load,
  input logic       alu_left_en,
  input logic       alu_right_en,
  input logic       lookup_en,
  input logic       mc_start,
  input logic [2:0] phase
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (phase == 3'd0 && !mc_start && !alu_left_en && !alu_right_en && !lookup_en));

  a_r2_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd0 && !bus_done) |=> phase == 3'd0);

  a_r7_start_single: assert property (@(posedge clk) disable iff (rst)
    mc_start |=> !mc_start);

  a_r7_start_phase: assert property (@(posedge clk) disable iff (rst)
    mc_start |-> (phase == 3'd1 || phase == 3'd2 || phase == 3'd4));

  a_r8_done_in_start: assert property (@(posedge clk) disable iff (rst)
    (mc_start && mc_done) |=> $stable(phase));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_req, alu_left_en, alu_right_en, lookup_en}));

  a_r10_lookup_one: assert property (@(posedge clk) disable iff (rst)
    lookup_en |=> (!lookup_en && phase == 3'd4 && mc_start));

  a_r11_exec_return: assert property (@(posedge clk) disable iff (rst)
    (phase == 3'd4 && mc_done && !mc_start) |=> phase == 3'd0);

  a_r2_load_only_fetch: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> fetch_req);
endmodule

bind instr_seq instr_seq_chk u_chk (
  .clk(clk), .rst(rst), .bus_done(bus_done), .mc_done(mc_done),
  .fetch_req(fetch_req), .ir_load(ir_load), .alu_left_en(alu_left_en),
  .alu_right_en(alu_right_en), .lookup_en(lookup_en),
  .mc_start(mc_start), .phase(phase)
);

// File: tb/instr_seq_tb.sv
`timescale 1ns/1ps
module instr_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = 16'h0;
  logic        bus_done = 1'b0;
  logic        mc_done = 1'b0;
  logic        fetch_req, ir_load, alu_left_en, alu_right_en;
  logic        op_grp_zero, lookup_en, mc_start;
  logic [2:0]  phase;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  instr_seq u_dut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .bus_done(bus_done),
    .mc_done(mc_done), .fetch_req(fetch_req), .ir_load(ir_load),
    .alu_left_en(alu_left_en), .alu_right_en(alu_right_en),
    .op_grp_zero(op_grp_zero), .lookup_en(lookup_en),
    .mc_start(mc_start), .phase(phase)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_entry(input logic [15:0] w);
    if (w[15:12] != 4'hF) return 1;
    if (w[11:9] == 3'b110) return 2;
    return 3;
  endfunction

  function automatic logic [15:0] gen_word(input int cls);
    logic [15:0] r = 16'($urandom);
    case (cls)
      0: begin r[15:12] = 4'($urandom % 15); end
      1: begin r[15:9] = 7'b1111_110; end
      2: begin r[15:11] = 5'b1111_0; end
      3: begin r[15:10] = 6'b1111_10; end
      default: begin r[15:6] = 10'h3FF; r[5:4] = 2'b00; end
    endcase
    return r;
  endfunction

  task automatic mc_phase(input int p, input int w, input bit early, input string tag);
    #1;
    chk(phase, p, tag);
    chk(mc_start, 1, "R7 start pulse");
    chk(alu_left_en, (p == 1), "R9 left");
    chk(alu_right_en, (p == 2), "R9 right");
    chk(op_grp_zero, (p != 4), "R9 group");
    mc_done = early;
    tick();
    mc_done = 0;
    #1;
    chk(phase, p, "R8 done in start cycle ignored");
    chk(mc_start, 0, "R7 single cycle");
    for (int i = 0; i < w; i++) begin
      bus_done = (p == 4);
      #1;
      chk(phase, p, "R8 hold");
      chk(ir_load, 0, "R2 no load outside fetch");
      tick();
      bus_done = 0;
    end
    mc_done = 1;
    tick();
    mc_done = 0;
  endtask

  task automatic run_instr(input logic [15:0] word, input int w, input bit early);
    int ent;
    string tag;
    for (int i = 0; i < w; i++) begin
      #1;
      chk(phase, 0, "R2 wait in fetch");
      chk(ir_load, 0, "R2 no load without bus_done");
      chk(fetch_req, 1, "R2 fetch_req");
      tick();
    end
    bus_done = 1;
    instr_word = word;
    #1;
    chk(ir_load, 1, "R2 load");
    tick();
    bus_done = 0;
    instr_word = 16'($urandom);
    ent = exp_entry(word);
    tag = (ent == 1) ? "R3 entry" : (ent == 2) ? "R4 entry" : "R5 entry";
    if (ent == 1) begin
      mc_phase(1, w, early, tag);
      tag = "R6 order";
    end
    if (ent <= 2) begin
      mc_phase(2, w, early, tag);
      tag = "R6 order";
    end
    #1;
    chk(phase, 3, tag);
    chk(lookup_en, 1, "R10 lookup strobe");
    chk(mc_start, 0, "R7 no start in lookup");
    chk(op_grp_zero, 0, "R9 group off");
    tick();
    mc_phase(4, w, early, "R10 exec follows lookup");
    #1;
    chk(phase, 0, "R11 back to fetch");
    chk(fetch_req, 1, "R11 fetch_req");
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    tick();
    #1;
    chk(phase, 0, "R1 reset phase");
    chk(mc_start, 0, "R1 reset start");
    chk(lookup_en | alu_left_en | alu_right_en | op_grp_zero, 0, "R1 reset strobes");
    rst = 0;
    tick();
    run_instr(16'hEFFF, 0, 1'b1);
    run_instr(16'hF000, 1, 1'b0);
    run_instr(16'hFC00, 2, 1'b1);
    run_instr(16'hFDFF, 0, 1'b0);
    run_instr(16'hFE00, 1, 1'b1);
    run_instr(16'hF800, 0, 1'b1);
    run_instr(16'hFFC5, 2, 1'b0);
    run_instr(16'h0000, 1, 1'b0);
    // R1: reset from the source phase
    bus_done = 1; instr_word = 16'h1234;
    tick();
    bus_done = 0;
    tick();
    rst = 1;
    tick();
    rst = 0;
    #1;
    chk(phase, 0, "R1 reset mid instruction");
    chk(mc_start, 0, "R1 reset mid start");
    tick();
    for (int n = 0; n < 60; n++)
      run_instr(gen_word(int'($urandom % 5)), int'($urandom % 4), 1'($urandom));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule